// File: doc/BRIEF.md
# Linear Burst Bus-Master Sequencer

This block runs a sequence of memory transfers for a bus master during a single period of bus ownership. A request supplies a start address, a transfer count, a direction and an access class. The sequencer then steps through the transfers. Each transfer is called a beat, and the address rises by four bytes per beat. A beat ends on a clock edge where the slave's ready input is high.

When the burst enable for the request's direction is set and the access carries data-buffer traffic, the address strobe is pulsed only for the first beat. The beats after it are data-only. The address bus still carries the correct incrementing address on every data-only beat, so a slave that decodes the address on each beat keeps working.

Control-structure traffic (descriptor and initialization accesses) is never burst. When the enable for the direction is clear, a strobe is issued for every beat. Bus arbitration and the data path sit outside this block.

Top module: `lbseq_top`

## Requirements
- R1: A request is accepted only while the sequencer is idle and only when its count is nonzero. A request raised during a run, or one with a count of zero, starts no beats and produces no done pulse.
- R2: The first beat drives the requested start address. Each completed beat raises `bus_addr` by 4. `bus_write` shows the captured direction (1 = write) during every beat.
- R3: A beat completes on the rising edge at which `bus_ready` is high. While `bus_ready` is low, the beat and its address are held.
- R4: For a data-buffer access (class code 0) with bursting enabled for its direction, only the first beat of the run asserts `addr_strobe`.
- R5: Read runs take their burst permission from `rd_burst_en` alone, and write runs from `wr_burst_en` alone.
- R6: Descriptor (class code 1) and initialization (class code 2) accesses, and any nonzero class code, assert `addr_strobe` on every beat, whatever the enables are.
- R7: When the enable for the run's direction is clear, every beat asserts `addr_strobe`.
- R8: `addr_strobe` is high only in the first clock of a beat and lasts exactly one clock per beat.
- R9: `done` is high for exactly one clock, in the cycle after the last beat completes. The sequencer is idle in the following cycle.
- R10: Direction, class and both enables are captured when a request is accepted. Changes to them during the run have no effect.
- R11: After reset the sequencer is idle, with `bus_active`, `addr_strobe`, `bus_write` and `done` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | AW | Start byte address |
| req_count | input | CW | Number of beats (0 = ignored) |
| req_write | input | 1 | Direction: 1 = write, 0 = read |
| req_class | input | 2 | Access class: 0 data buffer, 1 descriptor, 2 initialization |
| rd_burst_en | input | 1 | Permit data-only beats on reads |
| wr_burst_en | input | 1 | Permit data-only beats on writes |
| bus_ready | input | 1 | Slave ready; ends the current beat |
| bus_addr | output | AW | Address of the current beat |
| addr_strobe | output | 1 | Address strobe, one clock at the start of a beat |
| bus_write | output | 1 | Direction of the current beat |
| bus_active | output | 1 | High during every beat cycle |
| done | output | 1 | One-clock pulse after the last beat |

## Verification
A fault in the captured burst decision shows in the second beat of a run: that beat either gains a strobe it should not have, or loses one it should have. A fault in the beat counter shows as a missing or extra beat before the `done` pulse, so the run ends too early or too late. An address fault shows on the `bus_addr` sampled at the completing edge of the first beat that follows the fault. Wait states are mixed into the stimulus so that a strobe held over several cycles, or an address that drifts during a wait, is caught within the beat where it happens.

// File: rtl/lbseq_pkg.sv
// Shared encodings for the linear burst sequencer.
// Assumes class codes arrive on a 2-bit field; only CLS_DATA may burst.
package lbseq_pkg;

    typedef enum logic [1:0] {
        CLS_DATA = 2'd0,
        CLS_DESC = 2'd1,
        CLS_INIT = 2'd2
    } acc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/lbseq_addr_gen.sv
// Beat address register.
// Loads the start address on accept and adds STEP each time a beat completes.
// Assumes load and step are never high together.
module lbseq_addr_gen #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Hold, load or advance the beat address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= start_addr;
        else if (step)
            addr <= addr + STEP_V;
    end
endmodule

// File: rtl/lbseq_beat_cnt.sv
// Remaining-beat counter.
// Loads the request count and counts down per completed beat.
// Assumes a nonzero load value.
module lbseq_beat_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] count_in,
    output logic          last_beat
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] remain_q;

    // Track how many beats are still owed in this run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= count_in;
        else if (step)
            remain_q <= remain_q - ONE;
    end

    // Flag the final beat of the run.
    always_comb last_beat = (remain_q == ONE);
endmodule

// File: rtl/lbseq_fsm.sv
// Run controller: idle / beat / done.
// Decides once, at accept, whether the run may use data-only beats.
// Issues the strobe in the first clock of each beat that needs one.
module lbseq_fsm
    import lbseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       count_nz,
    input  logic       req_write,
    input  logic [1:0] req_class,
    input  logic       rd_burst_en,
    input  logic       wr_burst_en,
    input  logic       bus_ready,
    input  logic       last_beat,
    output logic       accept,
    output logic       advance,
    output logic       addr_strobe,
    output logic       bus_active,
    output logic       bus_write,
    output logic       done
);
    seq_state_e state_q, state_d;
    logic       burst_ok_q;
    logic       write_q;
    logic       strobe_pend_q;
    logic       burst_now;

    // Burst permission for the incoming request.
    always_comb begin
        burst_now = (acc_class_e'(req_class) == CLS_DATA) &&
                    (req_write ? wr_burst_en : rd_burst_en);
    end

    // Handshake qualifiers.
    always_comb begin
        accept  = (state_q == ST_IDLE) && req_valid && count_nz;
        advance = (state_q == ST_BEAT) && bus_ready;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_BEAT;
            ST_BEAT: if (advance && last_beat) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture run attributes at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_ok_q <= 1'b0;
            write_q    <= 1'b0;
        end else if (accept) begin
            burst_ok_q <= burst_now;
            write_q    <= req_write;
        end
    end

    // Arm the strobe for the first beat, and for later beats only when not bursting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_pend_q <= 1'b0;
        else if (accept)
            strobe_pend_q <= 1'b1;
        else if (advance && !last_beat)
            strobe_pend_q <= !burst_ok_q;
        else if (state_q == ST_BEAT)
            strobe_pend_q <= 1'b0;
    end

    // Bus-side outputs.
    always_comb begin
        bus_active  = (state_q == ST_BEAT);
        addr_strobe = bus_active && strobe_pend_q;
        bus_write   = bus_active && write_q;
        done        = (state_q == ST_DONE);
    end
endmodule

// File: rtl/lbseq_top.sv
// Linear burst bus-master sequencer, top level.
// Joins the controller, address generator and beat counter.
// Assumes arbitration has already granted the bus while a run is active.
module lbseq_top #(
    parameter int AW   = 32,
    parameter int CW   = 8,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_count,
    input  logic          req_write,
    input  logic [1:0]    req_class,
    input  logic          rd_burst_en,
    input  logic          wr_burst_en,
    input  logic          bus_ready,
    output logic [AW-1:0] bus_addr,
    output logic          addr_strobe,
    output logic          bus_write,
    output logic          bus_active,
    output logic          done
);
    logic accept;
    logic advance;
    logic last_beat;
    logic count_nz;

    // A zero-length request is never started.
    always_comb count_nz = (req_count != '0);

    lbseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .count_nz    (count_nz),
        .req_write   (req_write),
        .req_class   (req_class),
        .rd_burst_en (rd_burst_en),
        .wr_burst_en (wr_burst_en),
        .bus_ready   (bus_ready),
        .last_beat   (last_beat),
        .accept      (accept),
        .advance     (advance),
        .addr_strobe (addr_strobe),
        .bus_active  (bus_active),
        .bus_write   (bus_write),
        .done        (done)
    );

    lbseq_addr_gen #(.AW(AW), .STEP(STEP)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .step       (advance),
        .start_addr (req_addr),
        .addr       (bus_addr)
    );

    lbseq_beat_cnt #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (advance),
        .count_in  (req_count),
        .last_beat (last_beat)
    );
endmodule

// File: rtl/lbseq_chk.sv
// Protocol checker for lbseq_top, attached by bind.
// Watches only the top-level ports.
module lbseq_chk #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          addr_strobe,
    input logic          bus_write,
    input logic          bus_active,
    input logic          bus_ready,
    input logic          done
);
    // R8
    strobe_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && !bus_ready) |=> !addr_strobe);

    // R3
    wait_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !bus_ready) |=> (bus_active && $stable(bus_addr)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && bus_ready) |=> (done || bus_addr == $past(bus_addr) + AW'(STEP)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !bus_active));

    // R9
    done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_active && bus_ready));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |-> (!addr_strobe && !bus_write));
endmodule

bind lbseq_top lbseq_chk #(.AW(AW), .STEP(STEP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .addr_strobe (addr_strobe),
    .bus_write   (bus_write),
    .bus_active  (bus_active),
    .bus_ready   (bus_ready),
    .done        (done)
);

// File: tb/lbseq_top_tb.sv
// Scoreboard bench: the driver queues the expected beats, the monitor pops and compares them.
module lbseq_top_tb;
    localparam int AW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic          req_write = 1'b0;
    logic [1:0]    req_class = 2'd0;
    logic          rd_burst_en = 1'b0;
    logic          wr_burst_en = 1'b0;
    logic          bus_ready = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          addr_strobe;
    logic          bus_write;
    logic          bus_active;
    logic          done;

    int n_chk = 0;
    int n_fail = 0;
    int pend_done = 0;
    logic [AW+1:0] exp_q [$];   // {write, strobe, addr}

    always #5 clk = ~clk;

    lbseq_top #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_count(req_count), .req_write(req_write), .req_class(req_class),
        .rd_burst_en(rd_burst_en), .wr_burst_en(wr_burst_en), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .addr_strobe(addr_strobe), .bus_write(bus_write),
        .bus_active(bus_active), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic bit ready_at(input int mode, input int cyc);
        case (mode)
            1:       return (cyc % 3) == 0;
            2:       return (cyc % 2) == 0;
            default: return 1'b1;
        endcase
    endfunction

    // Driver: queue expected beats, issue one request, pace ready until done.
    task automatic run(input logic [AW-1:0] a, input int cnt, input bit wr, input logic [1:0] cls,
                       input bit rd_en, input bit wr_en, input int mode, input bit disturb);
        bit burst;
        int cyc;
        burst = (cls == 2'd0) && (wr ? wr_en : rd_en);
        for (int i = 0; i < cnt; i++)
            exp_q.push_back({wr, (i == 0) || !burst, a + AW'(4 * i)});
        pend_done++;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_count = CW'(cnt); req_write = wr;
        req_class = cls; rd_burst_en = rd_en; wr_burst_en = wr_en; bus_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done) begin
            bus_ready = ready_at(mode, cyc);
            if (disturb && cyc == 2) begin
                // R1 / R10: a second request and flipped attributes mid-run
                req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_count = 8'd3;
                req_write = ~wr; req_class = 2'd0;
                rd_burst_en = ~rd_en; wr_burst_en = ~wr_en;
            end
            if (cyc == 3) req_valid = 1'b0;
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        bus_ready = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare every completed beat and every done pulse.
    int  beat_cyc = 0;
    bit  strobe_seen = 1'b0;
    bit  prev_done = 1'b0;
    bit  prev_complete = 1'b0;
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #8;
            if (prev_done)
                chk(!done && !bus_active, "R9 done width / idle after", {62'd0, done, bus_active}, 64'd0);
            if (done) begin
                chk(prev_complete && !bus_active, "R9 done follows last beat", {63'd0, prev_complete}, 64'd1);
                chk(pend_done > 0, "R1 unexpected done", 64'(pend_done), 64'd1);
                chk(exp_q.size() == 0, "R9 beats owed at done", 64'(exp_q.size()), 64'd0);
                if (pend_done > 0) pend_done--;
            end
            if (!bus_active && (addr_strobe || bus_write))
                chk(1'b0, "R11 strobe/write while idle", {62'd0, addr_strobe, bus_write}, 64'd0);
            if (bus_active) begin
                if (addr_strobe && beat_cyc != 0)
                    chk(1'b0, "R8 strobe after first clock of beat", 64'(beat_cyc), 64'd0);
                strobe_seen = strobe_seen | addr_strobe;
                if (bus_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1 unexpected beat", 64'(bus_addr), 64'd0);
                    end else begin
                        logic [AW+1:0] e;
                        e = exp_q.pop_front();
                        chk(bus_addr == e[AW-1:0], "R2 beat address", 64'(bus_addr), 64'(e[AW-1:0]));
                        chk(bus_write == e[AW+1], "R2 beat direction", 64'(bus_write), 64'(e[AW+1]));
                        chk(strobe_seen == e[AW], "R4/R5/R6/R7 strobe on beat", 64'(strobe_seen), 64'(e[AW]));
                    end
                    beat_cyc = 0;
                    strobe_seen = 1'b0;
                end else begin
                    beat_cyc++;
                end
            end
            prev_complete = bus_active && bus_ready;
            prev_done = done;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({bus_active, addr_strobe, bus_write, done} == 4'b0, "R11 reset outputs",
            {60'd0, bus_active, addr_strobe, bus_write, done}, 64'd0);

        // R4 data read burst, no wait states
        run(32'h0000_1000, 4, 1'b0, 2'd0, 1'b1, 1'b0, 0, 1'b0);
        // R5 read ignores write enable; R7 strobe each beat
        run(32'h0000_2000, 3, 1'b0, 2'd0, 1'b0, 1'b1, 0, 1'b0);
        // R4 R3 data write burst with wait states
        run(32'h0000_3000, 5, 1'b1, 2'd0, 1'b0, 1'b1, 1, 1'b0);
        // R5 write ignores read enable
        run(32'h0000_4000, 3, 1'b1, 2'd0, 1'b1, 1'b0, 2, 1'b0);
        // R6 descriptor read never bursts
        run(32'h0000_5000, 4, 1'b0, 2'd1, 1'b1, 1'b1, 0, 1'b0);
        // R6 initialization write never bursts
        run(32'h0000_6000, 3, 1'b1, 2'd2, 1'b1, 1'b1, 1, 1'b0);
        // R9 single-beat run
        run(32'h0000_7000, 1, 1'b0, 2'd0, 1'b1, 1'b1, 1, 1'b0);
        // R1 R10 busy request ignored and attributes frozen
        run(32'h0000_8000, 6, 1'b0, 2'd0, 1'b1, 1'b0, 1, 1'b1);
        // R2 address wrap at the top of the space
        run(32'hFFFF_FFF8, 4, 1'b1, 2'd0, 1'b0, 1'b1, 0, 1'b0);

        // R1 zero-count request ignored
        @(negedge clk);
        req_valid = 1'b1; req_count = '0; req_addr = 32'h0000_9000;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk(!bus_active && !done, "R1 zero count starts nothing", {62'd0, bus_active, done}, 64'd0);
            @(negedge clk);
        end
        chk(exp_q.size() == 0 && pend_done == 0, "R9 scoreboard drained",
            64'(exp_q.size() + pend_done), 64'd0);
        report();
    end
endmodule